// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit counter with a 16-bit companion register that serves as a capture latch or as a reload value, depending on the mode. The counter can count a divided system clock or falling edges on an external count pin. It has four behaviours. In capture mode, a falling edge on the trigger pin copies the live count into the companion register. In auto-reload mode, the counter reloads on overflow or on a trigger edge, and can optionally count down with its direction set by the trigger pin level. In baud mode, each wrap emits one-cycle receive and/or transmit ticks for a serial port. In clock-out mode, a pin toggles on every wrap.

Software reaches the block through a byte-wide register port: address, write data, write enable and a combinational read-back. The overflow and trigger flags are sticky until software rewrites them. The interrupt request is derived from these flags. The serial port that uses the ticks lies outside the block.

Top module: `tmr16_top`

## Requirements
- R1: After reset, all six registers read back as zero, addresses 6 and 7 read back as zero, and every flag, tick and clock-out output is low.
- R2: With the internal source selected (control bit 1 = 0) and the block running (control bit 2 = 1), the count advances once every 12 clocks. With bit 1 = 1, it advances once per falling edge of the count pin. That edge is seen one clock after the pin is sampled low.
- R3: In auto-reload mode (control bit 0 = 0, mode bit 0 = 0), a count step from 0xFFFF loads the reload value and sets the overflow flag (control bit 7).
- R4: In auto-reload mode with trigger enable (control bit 3) set, a falling edge on the trigger pin while running loads the reload value and sets the external flag (control bit 6).
- R5: In capture mode (control bit 0 = 1), a step from 0xFFFF wraps to 0 and sets the overflow flag. A trigger edge with trigger enable set copies the count into the capture register and sets the external flag.
- R6: With down-count enable (mode bit 0) set in auto-reload mode, a low trigger pin makes the counter count down and a high pin makes it count up. A down step taken while the count equals the reload value loads 0xFFFF. Each down underflow or up overflow sets the overflow flag and toggles the external flag, and trigger edges have no other effect.
- R7: The interrupt request is high when the overflow flag is set, or when the external flag is set and up/down mode is not active.
- R8: When receive select (control bit 5) or transmit select (control bit 4) is set, the count advances every 2 clocks. Each wrap loads the reload value and gives a one-cycle pulse on each selected tick output. The overflow flag is not set.
- R9: When clock-out (mode bit 1) is set with the internal source, the count advances every 2 clocks and each wrap reloads and toggles the clock-out pin, without setting the overflow flag.
- R10: Writes use addresses 0 (control), 1 (mode), 2 and 3 (count low and high byte), 4 and 5 (reload/capture low and high byte). Flags take the written value, except that a flag set or toggled by hardware in the same cycle keeps the hardware value. Count and capture-register writes override the update made by the counter in that cycle. Reads return the same layout.
- R11: While control bit 2 is clear, the count holds its value, trigger edges have no effect, and the prescaler restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin_i | input | 1 | External count pin |
| trig_pin_i | input | 1 | Trigger / direction pin |
| we_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| irq_o | output | 1 | Interrupt request |
| rx_tick_o | output | 1 | Receive baud tick |
| tx_tick_o | output | 1 | Transmit baud tick |
| clk_out_o | output | 1 | Clock-out pin |

## Verification
The bench targets these cases:
- The exact wrap points: 0xFFFF going up, and the count meeting the reload value going down. A design that is off by one there would reload one step early or late, or would reload the wrong constant on underflow.
- The interrupt mask for the external flag in up/down mode. A wrong mask would raise a spurious interrupt when only the 17th-bit flag is set.
- The fast timebase of the baud and clock-out modes. Getting it wrong shows up as the wrong pulse or toggle count over a fixed window, or as a stray overflow flag.
- The write priority over flags and the counter. Long random runs with writes mixed in check this every cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL  = 3'd0,
        ADR_MODE  = 3'd1,
        ADR_CNT_L = 3'd2,
        ADR_CNT_H = 3'd3,
        ADR_CAP_L = 3'd4,
        ADR_CAP_H = 3'd5
    } adr_e;

    typedef struct packed {
        logic ofl;      // overflow flag
        logic ext;      // external flag
        logic rx_sel;   // receive baud select
        logic tx_sel;   // transmit baud select
        logic ext_en;   // trigger pin enable
        logic run;      // counter running
        logic evt_src;  // count pin edges instead of prescaler
        logic cap_mode; // capture instead of auto-reload
    } ctrl_t;

    localparam int PIN_CNT  = 0;
    localparam int PIN_TRIG = 1;
    localparam int NPIN     = 2;

endpackage

// File: rtl/tmr16_pin_edge.sv
module tmr16_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1};
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s1;
    assign fall_o = st_q.s2 & ~st_q.s1;

    // R2: a single falling transition yields a single-cycle event
    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fast_i,
    output logic tick_o
);
    localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] SLOW_LAST = PW'(SLOW_DIV - 1);
    localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] last;

    always_comb begin
        last   = fast_i ? FAST_LAST : SLOW_LAST;
        tick_o = en_i && (st_q.cnt >= last);
        st_d   = st_q;
        if (!en_i || tick_o) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: divider state never leaves the slow range
    a_r2_presc_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= SLOW_LAST);

    // R11: a stopped prescaler sits at zero
    a_r11_presc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> st_q.cnt == '0);

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top #(
    parameter int CW       = 16,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_pin_i,
    input  logic       trig_pin_i,
    input  logic       we_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       ovf_flag_o,
    output logic       ext_flag_o,
    output logic       irq_o,
    output logic       rx_tick_o,
    output logic       tx_tick_o,
    output logic       clk_out_o
);
    import tmr16_pkg::*;

    localparam int HB = CW - 8;

    typedef struct packed {
        ctrl_t         ctrl;
        logic          down_en;
        logic          clko_en;
        logic [CW-1:0] cnt;
        logic [CW-1:0] cap;
        logic          clk_out;
        logic          rx_tick;
        logic          tx_tick;
    } st_t;

    st_t st_d, st_q;

    logic [NPIN-1:0] pin_raw, pin_lvl, pin_fall;
    logic clko_act, fast_mode, updown, dir_up, presc_tick, tick, trig;
    logic hw_ofl, hw_ext, ext_hw;
    ctrl_t wr;

    assign pin_raw[PIN_CNT]  = cnt_pin_i;
    assign pin_raw[PIN_TRIG] = trig_pin_i;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        tmr16_pin_edge i_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_raw[g]),
            .lvl_o  (pin_lvl[g]),
            .fall_o (pin_fall[g])
        );
    end

    assign clko_act  = st_q.clko_en & ~st_q.ctrl.evt_src;
    assign fast_mode = st_q.ctrl.rx_sel | st_q.ctrl.tx_sel | clko_act;
    assign updown    = st_q.down_en & ~st_q.ctrl.cap_mode & ~fast_mode;
    assign dir_up    = pin_lvl[PIN_TRIG];

    tmr16_presc #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (st_q.ctrl.run & ~st_q.ctrl.evt_src),
        .fast_i (fast_mode),
        .tick_o (presc_tick)
    );

    assign tick = st_q.ctrl.evt_src ? (st_q.ctrl.run & pin_fall[PIN_CNT]) : presc_tick;
    assign trig = st_q.ctrl.run & st_q.ctrl.ext_en & pin_fall[PIN_TRIG];

    always_comb begin
        st_d         = st_q;
        st_d.rx_tick = 1'b0;
        st_d.tx_tick = 1'b0;
        hw_ofl       = 1'b0;
        hw_ext       = 1'b0;
        wr           = ctrl_t'(wdata_i);

        // counting step
        if (tick) begin
            if (updown && !dir_up) begin
                if (st_q.cnt == st_q.cap) begin
                    st_d.cnt      = '1;
                    st_d.ctrl.ofl = 1'b1;
                    st_d.ctrl.ext = ~st_q.ctrl.ext;
                    hw_ofl        = 1'b1;
                    hw_ext        = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end else if (st_q.cnt == '1) begin
                if (fast_mode) begin
                    st_d.cnt     = st_q.cap;
                    st_d.rx_tick = st_q.ctrl.rx_sel;
                    st_d.tx_tick = st_q.ctrl.tx_sel;
                    if (clko_act) st_d.clk_out = ~st_q.clk_out;
                end else begin
                    st_d.cnt      = st_q.ctrl.cap_mode ? '0 : st_q.cap;
                    st_d.ctrl.ofl = 1'b1;
                    hw_ofl        = 1'b1;
                    if (updown) begin
                        st_d.ctrl.ext = ~st_q.ctrl.ext;
                        hw_ext        = 1'b1;
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        // trigger pin event
        if (trig && !updown) begin
            st_d.ctrl.ext = 1'b1;
            hw_ext        = 1'b1;
            if (!fast_mode) begin
                if (st_q.ctrl.cap_mode) st_d.cap = st_q.cnt;
                else                    st_d.cnt = st_q.cap;
            end
        end

        ext_hw = st_d.ctrl.ext;

        // register writes
        if (we_i) begin
            case (addr_i)
                ADR_CTRL: begin
                    st_d.ctrl     = wr;
                    st_d.ctrl.ofl = wr.ofl | hw_ofl;
                    st_d.ctrl.ext = hw_ext ? ext_hw : wr.ext;
                end
                ADR_MODE: begin
                    st_d.down_en = wdata_i[0];
                    st_d.clko_en = wdata_i[1];
                end
                ADR_CNT_L: st_d.cnt[7:0]    = wdata_i;
                ADR_CNT_H: st_d.cnt[CW-1:8] = wdata_i[HB-1:0];
                ADR_CAP_L: st_d.cap[7:0]    = wdata_i;
                ADR_CAP_H: st_d.cap[CW-1:8] = wdata_i[HB-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            ADR_CTRL:  rdata_o = st_q.ctrl;
            ADR_MODE:  rdata_o = {6'b0, st_q.clko_en, st_q.down_en};
            ADR_CNT_L: rdata_o = st_q.cnt[7:0];
            ADR_CNT_H: rdata_o = 8'(st_q.cnt[CW-1:8]);
            ADR_CAP_L: rdata_o = st_q.cap[7:0];
            ADR_CAP_H: rdata_o = 8'(st_q.cap[CW-1:8]);
            default:   rdata_o = '0;
        endcase
    end

    assign ovf_flag_o = st_q.ctrl.ofl;
    assign ext_flag_o = st_q.ctrl.ext;
    assign irq_o      = st_q.ctrl.ofl | (st_q.ctrl.ext & ~updown);
    assign rx_tick_o  = st_q.rx_tick;
    assign tx_tick_o  = st_q.tx_tick;
    assign clk_out_o  = st_q.clk_out;

    // R6: a down step at the reload value lands on all-ones with the flag set
    a_r6_underflow_load: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && updown && !dir_up && st_q.cnt == st_q.cap && !we_i)
        |=> (st_q.cnt == '1 && st_q.ctrl.ofl));

    // R7: a set overflow flag always requests service
    a_r7_irq_on_ofl: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.ofl |-> irq_o);

    // R8: a receive tick only follows a cycle with receive select set
    a_r8_rx_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick_o |-> $past(st_q.ctrl.rx_sel));

    // R9: the clock-out pin moves only on a wrap in clock-out mode
    a_r9_clk_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out_o) |-> ($past(st_q.cnt) == '1 && $past(clko_act)));

    // R11: stopped and unwritten means the count holds
    a_r11_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !we_i) |=> $stable(st_q.cnt));

endmodule

// File: tb/test_tmr16_top.sv
`timescale 1ns/1ps
module test_tmr16_top;
    localparam int SLOW = 12;
    localparam int FAST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpin = 1'b1, xpin = 1'b1, we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ovf, extf, irq, rxt, txt, clko;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr16_top i_tmr16_top (
        .clk(clk), .rst_n(rst_n), .cnt_pin_i(cpin), .trig_pin_i(xpin),
        .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .ovf_flag_o(ovf), .ext_flag_o(extf), .irq_o(irq),
        .rx_tick_o(rxt), .tx_tick_o(txt), .clk_out_o(clko)
    );

    // reference model state
    logic [15:0] m_cnt = 0, m_cap = 0;
    logic m_ofl = 0, m_ext = 0, m_rxs = 0, m_txs = 0, m_exen = 0, m_run = 0;
    logic m_evt = 0, m_capm = 0, m_dn = 0, m_clko = 0, m_clk = 0, m_rxt = 0, m_txt = 0;
    logic m_cp1 = 1, m_cp2 = 1, m_xp1 = 1, m_xp2 = 1;
    int   m_pc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_fast();
        return m_rxs | m_txs | (m_clko & ~m_evt);
    endfunction

    function automatic logic m_ud();
        return m_dn & ~m_capm & ~m_fast();
    endfunction

    function automatic logic [7:0] rd_exp(input logic [2:0] a);
        case (a)
            3'd0: return {m_ofl, m_ext, m_rxs, m_txs, m_exen, m_run, m_evt, m_capm};
            3'd1: return {6'b0, m_clko, m_dn};
            3'd2: return m_cnt[7:0];
            3'd3: return m_cnt[15:8];
            3'd4: return m_cap[7:0];
            3'd5: return m_cap[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string mtag();
        if (m_fast()) return "R8";
        if (m_ud())   return "R6";
        if (m_capm)   return "R5";
        return "R3";
    endfunction

    task automatic model_step();
        logic fast, cka, pen, ptick, cfall, xfall, tick, ud, trig, hwo, hwe;
        logic [15:0] ncnt, ncap;
        logic nofl, next_, nclk, nrxt, ntxt, exh;
        int lim;
        #0.1;
        chk("R10 read", rdata, rd_exp(addr));
        cka   = m_clko & ~m_evt;
        fast  = m_fast();
        lim   = fast ? FAST : SLOW;
        pen   = m_run & ~m_evt;
        ptick = pen && (m_pc >= lim - 1);
        cfall = m_cp2 & ~m_cp1;
        xfall = m_xp2 & ~m_xp1;
        tick  = m_evt ? (m_run & cfall) : ptick;
        ud    = m_ud();
        trig  = m_run & m_exen & xfall;
        ncnt = m_cnt; ncap = m_cap; nofl = m_ofl; next_ = m_ext; nclk = m_clk;
        nrxt = 0; ntxt = 0; hwo = 0; hwe = 0;
        if (tick) begin
            if (ud && !m_xp1) begin
                if (m_cnt == m_cap) begin
                    ncnt = 16'hFFFF; nofl = 1; next_ = ~m_ext; hwo = 1; hwe = 1;
                end else ncnt = m_cnt - 1;
            end else if (m_cnt == 16'hFFFF) begin
                if (fast) begin
                    ncnt = m_cap; nrxt = m_rxs; ntxt = m_txs;
                    if (cka) nclk = ~m_clk;
                end else begin
                    ncnt = m_capm ? 16'h0 : m_cap; nofl = 1; hwo = 1;
                    if (ud) begin next_ = ~m_ext; hwe = 1; end
                end
            end else ncnt = m_cnt + 1;
        end
        if (trig && !ud) begin
            next_ = 1; hwe = 1;
            if (!fast) begin
                if (m_capm) ncap = m_cnt;
                else        ncnt = m_cap;
            end
        end
        exh = next_;
        if (we) begin
            case (addr)
                3'd0: begin
                    nofl = wdata[7] | hwo;
                    next_ = hwe ? exh : wdata[6];
                    m_rxs = wdata[5]; m_txs = wdata[4]; m_exen = wdata[3];
                    m_run = wdata[2]; m_evt = wdata[1]; m_capm = wdata[0];
                end
                3'd1: begin m_dn = wdata[0]; m_clko = wdata[1]; end
                3'd2: ncnt[7:0]  = wdata;
                3'd3: ncnt[15:8] = wdata;
                3'd4: ncap[7:0]  = wdata;
                3'd5: ncap[15:8] = wdata;
                default: ;
            endcase
        end
        m_pc  = (!pen || ptick) ? 0 : m_pc + 1;
        m_cp2 = m_cp1; m_cp1 = cpin;
        m_xp2 = m_xp1; m_xp1 = xpin;
        m_cnt = ncnt; m_cap = ncap; m_ofl = nofl; m_ext = next_;
        m_clk = nclk; m_rxt = nrxt; m_txt = ntxt;
    endtask

    task automatic check_outs();
        string t;
        t = mtag();
        chk({t, " ovf flag"}, ovf, m_ofl);
        chk({t, " ext flag"}, extf, m_ext);
        chk("R7 irq", irq, m_ofl | (m_ext & ~m_ud()));
        chk("R8 rx tick", rxt, m_rxt);
        chk("R8 tx tick", txt, m_txt);
        chk("R9 clk out", clko, m_clk);
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_outs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        we = 1; addr = a; wdata = d;
        cyc();
        we = 0;
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 3'd1, v[15:8]);
    endtask

    function automatic int rd_now_unused(); return 0; endfunction

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        addr = a;     #0.1; v[7:0]  = rdata;
        addr = a + 1; #0.1; v[15:8] = rdata;
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk("R1 ovf", ovf, 0); chk("R1 ext", extf, 0); chk("R1 irq", irq, 0);
        chk("R1 rx", rxt, 0);  chk("R1 tx", txt, 0);   chk("R1 clk", clko, 0);
        for (int a = 0; a < 8; a++) begin
            addr = 3'(a); #0.1;
            chk("R1 reg", rdata, 0);
        end

        // R2: internal timebase, one step per 12 clocks
        wr(3'd0, 8'h04);
        idle(24);
        rd16(3'd2, v); chk("R2 count after 24", v, 16'h0002);
        wr(3'd0, 8'h00);

        // R3: overflow reload
        wr16(3'd2, 16'hFFFE); wr16(3'd4, 16'h1234);
        wr(3'd0, 8'h04);
        idle(24);
        rd16(3'd2, v); chk("R3 reload value", v, 16'h1234);
        chk("R3 ovf set", ovf, 1); chk("R7 irq from ovf", irq, 1);
        // R10: software clears flag
        wr(3'd0, 8'h04);
        chk("R10 ovf cleared", ovf, 0); chk("R10 irq cleared", irq, 0);
        wr(3'd0, 8'h00);

        // R4: trigger reload
        wr16(3'd4, 16'h0200); wr16(3'd2, 16'h0010);
        wr(3'd0, 8'h0C);
        idle(3); xpin = 0; idle(4);
        rd16(3'd2, v); chk("R4 trig reload", v, 16'h0200);
        chk("R4 ext set", extf, 1); chk("R7 irq from ext", irq, 1);
        xpin = 1; wr(3'd0, 8'h00);

        // R5: capture and wrap to zero
        wr16(3'd2, 16'h0345);
        wr(3'd0, 8'h0D);
        idle(2); xpin = 0; idle(4);
        rd16(3'd4, v); chk("R5 captured", v, 16'h0345);
        chk("R5 ext set", extf, 1);
        xpin = 1; wr(3'd0, 8'h01);
        wr16(3'd2, 16'hFFFF);
        wr(3'd0, 8'h05);
        idle(12);
        rd16(3'd2, v); chk("R5 wrap zero", v, 16'h0000);
        chk("R5 ovf set", ovf, 1);
        wr(3'd0, 8'h00);

        // R6: down count and underflow
        wr(3'd1, 8'h01); wr16(3'd4, 16'h0005); wr16(3'd2, 16'h0007);
        xpin = 0; idle(3);
        wr(3'd0, 8'h04);
        idle(36);
        rd16(3'd2, v); chk("R6 underflow load", v, 16'hFFFF);
        chk("R6 ovf", ovf, 1); chk("R6 ext toggled", extf, 1);
        wr(3'd0, 8'h44);
        chk("R7 ext masked in updown", irq, 0);
        xpin = 1; idle(30);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);

        // R8: baud ticks
        wr16(3'd4, 16'hFFFC); wr16(3'd2, 16'hFFFC);
        wr(3'd0, 8'h24);
        n = 0;
        for (int i = 0; i < 80; i++) begin
            cyc();
            if (rxt) n++;
            chk("R8 no tx", txt, 0);
        end
        chk("R8 rx pulses", n, 10); chk("R8 no ovf", ovf, 0);
        wr(3'd0, 8'h00);

        // R9: clock-out toggles
        wr(3'd1, 8'h02); wr16(3'd4, 16'hFFFE); wr16(3'd2, 16'hFFFE);
        wr(3'd0, 8'h04);
        n = 0;
        for (int i = 0; i < 80; i++) begin
            logic prev;
            prev = clko;
            cyc();
            if (clko != prev) n++;
        end
        chk("R9 toggles", n, 20); chk("R9 no ovf", ovf, 0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);

        // R2: event counting on count pin
        wr16(3'd2, 16'h0000);
        wr(3'd0, 8'h06);
        for (int i = 0; i < 5; i++) begin
            cpin = 0; idle(3); cpin = 1; idle(3);
        end
        rd16(3'd2, v); chk("R2 events", v, 16'h0005);

        // R11: stopped counter holds
        wr(3'd0, 8'h04); idle(30); wr(3'd0, 8'h00);
        begin
            logic [15:0] held;
            rd16(3'd2, held);
            xpin = 0; idle(30); xpin = 1;
            rd16(3'd2, v); chk("R11 hold", v, held);
        end

        // random mix
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 24) == 0) begin
                we = 1; addr = 3'($urandom % 8); wdata = 8'($urandom);
                if (addr == 3'd0 && ($urandom % 2)) wdata[2] = 1'b1;
            end else begin
                we = 0; addr = 3'($urandom % 8);
            end
            if (($urandom % 4) == 0) cpin = ~cpin;
            if (($urandom % 6) == 0) xpin = ~xpin;
            cyc();
        end
        we = 0;

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule